// File: doc/BRIEF.md
# Frame-Sync Activity Standby Controller

This block sets the operating state of the two channels of a voice-band codec. It looks only at how the transmit and receive frame-sync inputs behave and at an active-low power-down pin. A channel whose frame sync stops pulsing drops into standby on its own, so software never has to act. When the pin is low, everything is powered down. The block also drives the enables for the serial data output and the time-slot strobe. The surrounding pad logic uses these enables to release the pins to high impedance.

The three asynchronous inputs each pass through a two-flop synchronizer on the system clock. A rising edge is then detected on each frame sync. Each channel has a timeout counter that advances only in cycles where the master-clock enable is high. The counter restarts on every frame-sync rising edge. It declares the channel stopped after `TIMEOUT` counted cycles with no edge. This limit is normally set a little above one frame period.

When the transmit channel stops while receive frames keep arriving, the output enables are not dropped at once. A small frame counter, advanced by receive frame-sync edges, releases them after `RELEASE_FRAMES` frames. When a channel comes back, it turns active on its first edge. The output enables come back only with the frame that follows that edge.

Top module: `fsync_standby_ctrl`

## Requirements
- R1: Channel states are encoded as 2'b00 active, 2'b01 standby and 2'b10 powered down. When `pdn_n` is low, both state outputs read powered down and both enables are low, whatever the frame syncs do. This takes effect two cycles after the pin falls.
- R2: A channel enters standby after `TIMEOUT` clock cycles with `mclk_en` high and no rising edge on its frame sync. Cycles with `mclk_en` low do not advance the count.
- R3: A channel in standby reports active from the first rising edge of its frame sync. The change is seen three cycles after the raw input rises.
- R4: When both frame syncs have stopped and `pdn_n` is high, both channels read standby and both enables are low.
- R5: When the transmit frame sync stops while the receive one keeps pulsing, only the transmit channel reads standby. The enables stay high until the `RELEASE_FRAMES`-th receive rising edge counted after that point, then fall. `RELEASE_FRAMES` is at most 5.
- R6: When the receive frame sync stops while the transmit one keeps pulsing, only the receive channel reads standby and both enables stay high.
- R7: After a pause or a power-up, the enables rise only at the second transmit rising edge: the first edge wakes the channel and the next one starts the frame. If transmit resumes while the enables are still waiting for release, they simply stay high.
- R8: After reset or after `pdn_n` returns high, both channels read standby until their own first frame-sync rising edge.
- R9: If the receive frame sync also stops while the transmit release is pending, the enables fall without waiting for further frames.
- R10: `dout_oe` and `tstrobe_oe` always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Power-down pin, low means powered down (asynchronous) |
| fs_tx | input | 1 | Transmit frame sync (asynchronous) |
| fs_rx | input | 1 | Receive frame sync (asynchronous) |
| mclk_en | input | 1 | Master-clock enable, qualifies timeout counting |
| tx_state | output | 2 | Transmit channel state (R1 encoding) |
| rx_state | output | 2 | Receive channel state (R1 encoding) |
| dout_oe | output | 1 | Serial data output enable |
| tstrobe_oe | output | 1 | Time-slot strobe output enable |

## Verification
The bench targets the delayed transmit release. A design that drops the enables at once, or one that counts transmit edges in place of receive edges, shows up as a mismatch against the reference model during the frames after the transmit stop. The bench also pulses transmit once after a pause. A design that re-enables the outputs on the wake-up edge turns them on one frame early. With `mclk_en` held low for longer than the timeout, a counter that ignores the enable sends active channels into standby. The bench then stops receive while the release is pending. A design that waits only for receive frames would then keep the outputs enabled forever.

// File: rtl/fss_pkg.sv
package fss_pkg;

  typedef enum logic [1:0] {
    CH_ACTIVE  = 2'b00,
    CH_STANDBY = 2'b01,
    CH_POWERDN = 2'b10
  } ch_state_e;

  typedef enum logic [1:0] {
    OE_OFF   = 2'b00,
    OE_ARMED = 2'b01,
    OE_ON    = 2'b10,
    OE_DRAIN = 2'b11
  } oe_state_e;

endpackage

// File: rtl/fss_sync.sv
module fss_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("fss_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/fss_activity_mon.sv
module fss_activity_mon #(
  parameter int TIMEOUT = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic pdn_ok,
  input  logic mclk_en,
  output logic edge_o,
  output logic stopped_o
);

  localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             stop_q;

  assign edge_o    = level & ~prev_q;
  assign stopped_o = stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stop_q <= 1'b1;
    end else if (!pdn_ok) begin
      cnt_q  <= '0;
      stop_q <= 1'b1;
    end else if (edge_o) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else if (!stop_q && mclk_en) begin
      if (cnt_q == LAST) stop_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_edge_wakes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_ok && edge_o |=> !stop_q);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_frozen_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_ok && !mclk_en && !edge_o |=> $stable(cnt_q) && $stable(stop_q));

endmodule

// File: rtl/fss_oe_ctrl.sv
module fss_oe_ctrl
  import fss_pkg::*;
#(
  parameter int RELEASE_FRAMES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_ok,
  input  logic tx_edge,
  input  logic rx_edge,
  input  logic tx_stopped,
  input  logic rx_stopped,
  output logic oe
);

  localparam int FC_W = (RELEASE_FRAMES > 1) ? $clog2(RELEASE_FRAMES) : 1;
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(RELEASE_FRAMES - 1);

  oe_state_e       st_q, st_d;
  logic [FC_W-1:0] fc_q, fc_d;

  always_comb begin
    st_d = st_q;
    fc_d = fc_q;
    if (!pdn_ok) begin
      st_d = OE_OFF;
      fc_d = '0;
    end else begin
      unique case (st_q)
        OE_OFF:   if (tx_edge) st_d = OE_ARMED;
        OE_ARMED: begin
          if (tx_edge)         st_d = OE_ON;
          else if (tx_stopped) st_d = OE_OFF;
        end
        OE_ON: begin
          if (!tx_edge && tx_stopped) begin
            if (rx_stopped) st_d = OE_OFF;
            else begin
              st_d = OE_DRAIN;
              fc_d = '0;
            end
          end
        end
        OE_DRAIN: begin
          if (tx_edge)         st_d = OE_ON;
          else if (rx_stopped) st_d = OE_OFF;
          else if (rx_edge) begin
            if (fc_q == FC_LAST) st_d = OE_OFF;
            else                 fc_d = fc_q + 1'b1;
          end
        end
        default: st_d = OE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= OE_OFF;
      fc_q <= '0;
    end else begin
      st_q <= st_d;
      fc_q <= fc_d;
    end
  end

  assign oe = (st_q == OE_ON) || (st_q == OE_DRAIN);

  assert_pd_forces_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_ok |=> st_q == OE_OFF);

  assert_full_standby_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stopped && rx_stopped && !tx_edge |=> st_q == OE_OFF);

  assert_drain_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fc_q <= FC_LAST);

  assert_no_early_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == OE_OFF |=> st_q != OE_ON);

  assert_rx_active_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_ok && st_q == OE_ON && !tx_stopped |=> st_q == OE_ON);

endmodule

// File: rtl/fsync_standby_ctrl.sv
module fsync_standby_ctrl
  import fss_pkg::*;
#(
  parameter int TIMEOUT        = 24,
  parameter int RELEASE_FRAMES = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdn_n,
  input  logic       fs_tx,
  input  logic       fs_rx,
  input  logic       mclk_en,
  output logic [1:0] tx_state,
  output logic [1:0] rx_state,
  output logic       dout_oe,
  output logic       tstrobe_oe
);

  localparam int N_CH = 2;

  logic [2:0]      sync_q;
  logic            pdn_ok;
  logic [N_CH-1:0] fs_lvl, fs_edge, fs_stop;
  logic            oe_raw;
  ch_state_e       ch_st [N_CH];

  fss_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({fs_rx, fs_tx, pdn_n}), .q(sync_q)
  );

  assign pdn_ok = sync_q[0];
  assign fs_lvl = sync_q[2:1];

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      fss_activity_mon #(.TIMEOUT(TIMEOUT)) u_mon (
        .clk(clk), .rst_n(rst_n), .level(fs_lvl[c]), .pdn_ok(pdn_ok),
        .mclk_en(mclk_en), .edge_o(fs_edge[c]), .stopped_o(fs_stop[c])
      );
      assign ch_st[c] = !pdn_ok    ? CH_POWERDN :
                        fs_stop[c] ? CH_STANDBY : CH_ACTIVE;
    end
  endgenerate

  fss_oe_ctrl #(.RELEASE_FRAMES(RELEASE_FRAMES)) u_oe (
    .clk(clk), .rst_n(rst_n), .pdn_ok(pdn_ok),
    .tx_edge(fs_edge[0]), .rx_edge(fs_edge[1]),
    .tx_stopped(fs_stop[0]), .rx_stopped(fs_stop[1]), .oe(oe_raw)
  );

  assign tx_state   = ch_st[0];
  assign rx_state   = ch_st[1];
  assign dout_oe    = oe_raw & pdn_ok;
  assign tstrobe_oe = oe_raw & pdn_ok;

  assert_release_standby_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pdn_ok) |-> fs_stop[0] && fs_stop[1]);

  assert_oe_needs_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !fs_stop[0]);

  initial begin
    if (RELEASE_FRAMES < 1 || RELEASE_FRAMES > 5)
      $error("RELEASE_FRAMES must be 1..5");
    if (TIMEOUT < 2)
      $error("TIMEOUT must be at least 2");
  end

endmodule

// File: tb/fsync_standby_ctrl_test.sv
module fsync_standby_ctrl_test;

  localparam int TO = 20;
  localparam int RF = 4;
  localparam int FRAME = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pdn_n = 1'b0, fs_tx = 1'b0, fs_rx = 1'b0, mclk_en = 1'b1;
  logic [1:0] tx_state, rx_state;
  logic dout_oe, tstrobe_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  bit tx_run = 0, rx_run = 0;
  int phase = 0;

  // behavioural reference state
  int t1, t2, tp, r1, r2, rp, p1, p2;
  int tc, rc, ts, rs, ost, fc;
  // ost: 0 off, 1 waiting for next frame, 2 on, 3 release pending

  always #2 clk = ~clk;

  fsync_standby_ctrl #(.TIMEOUT(TO), .RELEASE_FRAMES(RF)) uut (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
    .mclk_en(mclk_en), .tx_state(tx_state), .rx_state(rx_state),
    .dout_oe(dout_oe), .tstrobe_oe(tstrobe_oe)
  );

  task automatic model_reset();
    t1 = 0; t2 = 0; tp = 0; r1 = 0; r2 = 0; rp = 0; p1 = 0; p2 = 0;
    tc = 0; rc = 0; ts = 1; rs = 1; ost = 0; fc = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) begin
      int te, re, ts_o, rs_o;
      te = (t2 && !tp) ? 1 : 0;
      re = (r2 && !rp) ? 1 : 0;
      ts_o = ts; rs_o = rs;
      if (!p2) begin tc = 0; ts = 1; end
      else if (te) begin tc = 0; ts = 0; end
      else if (!ts && mclk_en) begin if (tc == TO - 1) ts = 1; else tc++; end
      if (!p2) begin rc = 0; rs = 1; end
      else if (re) begin rc = 0; rs = 0; end
      else if (!rs && mclk_en) begin if (rc == TO - 1) rs = 1; else rc++; end
      if (!p2) begin ost = 0; fc = 0; end
      else begin
        case (ost)
          0: if (te) ost = 1;
          1: if (te) ost = 2; else if (ts_o) ost = 0;
          2: if (!te && ts_o) begin if (rs_o) ost = 0; else begin ost = 3; fc = 0; end end
          default: begin
            if (te) ost = 2;
            else if (rs_o) ost = 0;
            else if (re) begin if (fc == RF - 1) ost = 0; else fc++; end
          end
        endcase
      end
      tp = t2; t2 = t1; t1 = fs_tx;
      rp = r2; r2 = r1; r1 = fs_rx;
      p2 = p1; p1 = pdn_n;
    end
  end

  function automatic int exp_state(int pd_ok, int stopped);
    if (!pd_ok) return 2;
    return stopped ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_compare();
    int oe_exp;
    oe_exp = ((ost == 2 || ost == 3) && p2) ? 1 : 0;
    chk("R1/R2/R3 tx_state vs model", tx_state, exp_state(p2, ts));
    chk("R1/R2/R3 rx_state vs model", rx_state, exp_state(p2, rs));
    chk("R5/R6/R7 dout_oe vs model", dout_oe, oe_exp);
    chk("R10 tstrobe_oe equals dout_oe", tstrobe_oe, dout_oe);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      model_compare();
      phase = (phase + 1) % FRAME;
      fs_tx = tx_run && (phase < 2);
      fs_rx = rx_run && (phase >= 4) && (phase < 6);
    end
  endtask

  task automatic tx_pulse();
    @(negedge clk); cycles++; model_compare(); fs_tx = 1'b1;
    @(negedge clk); cycles++; model_compare(); fs_tx = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1 reset tx powered down", tx_state, 2);
    chk("R1 reset oe low", dout_oe, 0);
    rst_n = 1'b1;
    pdn_n = 1'b1;
    step(10);
    chk("R8 tx standby after power-up", tx_state, 1);
    chk("R8 rx standby after power-up", rx_state, 1);
    chk("R8 oe low after power-up", dout_oe, 0);

    // single transmit pulse: wakes channel, no enable yet
    tx_pulse();
    step(5);
    chk("R3 tx active after first edge", tx_state, 0);
    chk("R7 oe still low after wake edge", dout_oe, 0);
    tx_pulse();
    step(5);
    chk("R7 oe high at next frame", dout_oe, 1);

    tx_run = 1; rx_run = 1;
    step(4 * FRAME);
    chk("R3 rx active", rx_state, 0);
    chk("R6 normal oe high", dout_oe, 1);

    // transmit stops, receive continues
    tx_run = 0;
    for (int k = 0; k < 200 && tx_state != 2'b01; k++) step(1);
    chk("R5 tx standby", tx_state, 1);
    chk("R5 rx still active", rx_state, 0);
    chk("R5 oe held right after tx standby", dout_oe, 1);
    step((RF + 1) * FRAME);
    chk("R5 oe released within frame limit", dout_oe, 0);

    // transmit resumes
    tx_run = 1;
    step(3 * FRAME);
    chk("R3 tx active again", tx_state, 0);
    chk("R7 oe back on", dout_oe, 1);

    // receive stops, transmit continues
    rx_run = 0;
    step(4 * FRAME);
    chk("R6 rx standby", rx_state, 1);
    chk("R6 tx active", tx_state, 0);
    chk("R6 oe stays high", dout_oe, 1);

    // both stop
    tx_run = 0;
    step(3 * FRAME);
    chk("R4 tx standby", tx_state, 1);
    chk("R4 rx standby", rx_state, 1);
    chk("R4 oe low", dout_oe, 0);

    // counting frozen while mclk_en is low
    tx_run = 1; rx_run = 1;
    step(4 * FRAME);
    mclk_en = 1'b0;
    tx_run = 0; rx_run = 0;
    step(6 * FRAME);
    chk("R2 tx held active with mclk_en low", tx_state, 0);
    chk("R2 rx held active with mclk_en low", rx_state, 0);
    mclk_en = 1'b1;
    step(TO + 4);
    chk("R2 tx standby once counting resumes", tx_state, 1);
    chk("R4 oe low after both stop", dout_oe, 0);

    // receive stops while release pending
    tx_run = 1; rx_run = 1;
    step(4 * FRAME);
    tx_run = 0;
    for (int k = 0; k < 200 && tx_state != 2'b01; k++) step(1);
    chk("R9 pending release begins with oe high", dout_oe, 1);
    rx_run = 0;
    step(3 * FRAME);
    chk("R9 oe dropped when rx stops", dout_oe, 0);

    // power down while running
    tx_run = 1; rx_run = 1;
    step(4 * FRAME);
    pdn_n = 1'b0;
    step(4);
    chk("R1 tx powered down", tx_state, 2);
    chk("R1 rx powered down", rx_state, 2);
    chk("R1 oe low in power-down", dout_oe, 0);
    step(2 * FRAME);
    pdn_n = 1'b1;
    step(4);
    chk("R8 standby after pin release", tx_state, 1);
    step(4 * FRAME);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule